// File: doc/BRIEF.md
# Mailbox Command Requester Sequencer

This block issues one command at a time to a power-management microcontroller through three mailbox registers: a message register, an argument register and a response register. A local requester hands over a message ID and a 32-bit argument with a valid/ready handshake. The sequencer then drives the whole exchange on a simple register master port and reports the outcome as a one-cycle `done` pulse.

The exchange has three phases. First, the block waits until the responder is no longer busy. It polls the response register, and a value of zero means busy. Next, it writes the command: the response register is cleared to zero, the argument is written, and the message ID is written last because that write starts the transaction. Finally, it polls the response register again and then reads back the argument register, where the responder leaves its reply data such as a frequency or a version number.

Each poll phase allows a bounded number of retries, with a fixed idle delay between reads. The delay is counted in clock cycles, derived from a cycles-per-microsecond parameter. A pre-command phase that stays busy aborts the command without any write. A post-command phase that stays busy ends with a timeout report that carries the message ID and the argument.

Top module: `mbox_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `reg_req`, `rsp_timeout` and `rsp_abort` are 0.
- R2: Each poll phase reads the response register (address 2) until it returns a nonzero word, making at most MAX_RETRY+1 reads. Between a busy (zero) read and the next read, `reg_req` stays low for exactly CYC_PER_US*POLL_US clock cycles.
- R3: If every pre-command read returns zero, the block issues no register write and pulses `done` with `rsp_abort`=1, `rsp_timeout`=0, `rsp_code`=0 and `rsp_word`=0.
- R4: A command is written in exactly this order: address 2 receives 0, then address 1 receives the argument, then address 0 receives the zero-extended message ID.
- R5: When a post-command read returns a nonzero word, `rsp_code` is its low 8 bits. The block then reads address 1 once, and `rsp_word` is the value read.
- R6: If every post-command read returns zero, `done` comes with `rsp_timeout`=1 and `rsp_code`=0. `rsp_word` is still the value read back from address 1, and `rsp_id`/`rsp_arg` hold the message ID and argument of the request.
- R7: A nonzero pre-command response other than 0x01 (for example 0xFC, busy-retry) does not stop the command. Its low 8 bits are reported on `rsp_pre_code`. `rsp_pre_code` is 0 after an abort.
- R8: `req_ready` is high only while no command is in flight, so a second request is accepted only after `done`. `done` lasts exactly one cycle, and `req_ready` is already high in that cycle.
- R9: Once `reg_req` is raised, the signals `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` hold steady until the cycle in which `reg_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_id | input | ID_W | Message ID |
| req_arg | input | DW | Command argument |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 2 | 0 message, 1 argument, 2 response |
| reg_wdata | output | DW | Write data |
| reg_rdata | input | DW | Read data, valid with reg_ack |
| reg_ack | input | 1 | Access complete |
| done | output | 1 | One-cycle completion pulse |
| rsp_code | output | CODE_W | Final response code |
| rsp_pre_code | output | CODE_W | Response seen before the command was issued |
| rsp_word | output | DW | Argument register read back |
| rsp_timeout | output | 1 | Post-command poll ran out of retries |
| rsp_abort | output | 1 | Pre-command poll ran out, nothing written |
| rsp_id | output | ID_W | Message ID of the finished request |
| rsp_arg | output | DW | Argument of the finished request |

## Verification
The sharpest coincidence is the last permitted poll. The read that finally returns nonzero and the exhaustion of the retry count can fall on the same cycle, and the nonzero data must win. The bench sweeps the number of leading busy reads in both phases across 0 to MAX_RETRY+1. This puts a completion exactly on the final retry, and then one read later. For each case the bench judges the abort and timeout flags, the code, the read-back word, the number of response reads and the idle gap between them against values it derives from those counts.

// File: rtl/mbox_seq.sv
module mbox_seq #(
  parameter int CYC_PER_US = 100,
  parameter int POLL_US    = 10,
  parameter int MAX_RETRY  = 200000,
  parameter int ID_W       = 8,
  parameter int DW         = 32,
  parameter int CODE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DW-1:0]     req_arg,
  output logic              reg_req,
  output logic              reg_we,
  output logic [1:0]        reg_addr,
  output logic [DW-1:0]     reg_wdata,
  input  logic [DW-1:0]     reg_rdata,
  input  logic              reg_ack,
  output logic              done,
  output logic [CODE_W-1:0] rsp_code,
  output logic [CODE_W-1:0] rsp_pre_code,
  output logic [DW-1:0]     rsp_word,
  output logic              rsp_timeout,
  output logic              rsp_abort,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DW-1:0]     rsp_arg
);
  localparam int DLY = CYC_PER_US * POLL_US;
  localparam int DCW = $clog2(DLY + 1);
  localparam int RCW = $clog2(MAX_RETRY + 1);
  localparam logic [1:0] A_MSG = 2'd0, A_ARG = 2'd1, A_RSP = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PRE_DLY, S_CLR, S_ARG, S_TRIG, S_POST_RD, S_POST_DLY, S_GET
  } state_t;

  state_t             state;
  logic [DCW-1:0]     dly;
  logic [RCW-1:0]     retry;
  logic [ID_W-1:0]    id_q;
  logic [DW-1:0]      arg_q;
  logic [CODE_W-1:0]  pre_q, code_q;
  logic               to_q;
  logic               rd_busy, last_try;

  assign req_ready = (state == S_IDLE);
  assign reg_req   = (state == S_PRE_RD) || (state == S_CLR) || (state == S_ARG) ||
                     (state == S_TRIG) || (state == S_POST_RD) || (state == S_GET);
  assign reg_we    = (state == S_CLR) || (state == S_ARG) || (state == S_TRIG);
  assign reg_addr  = (state == S_TRIG) ? A_MSG :
                     ((state == S_ARG) || (state == S_GET)) ? A_ARG : A_RSP;
  assign reg_wdata = (state == S_ARG)  ? arg_q :
                     (state == S_TRIG) ? DW'(id_q) : '0;
  assign rsp_id    = id_q;
  assign rsp_arg   = arg_q;
  assign rd_busy   = (reg_rdata == '0);
  assign last_try  = (retry == RCW'(MAX_RETRY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      dly          <= '0;
      retry        <= '0;
      id_q         <= '0;
      arg_q        <= '0;
      pre_q        <= '0;
      code_q       <= '0;
      to_q         <= 1'b0;
      done         <= 1'b0;
      rsp_code     <= '0;
      rsp_pre_code <= '0;
      rsp_word     <= '0;
      rsp_timeout  <= 1'b0;
      rsp_abort    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          id_q  <= req_id;
          arg_q <= req_arg;
          retry <= '0;
          pre_q <= '0;
          state <= S_PRE_RD;
        end
        S_PRE_RD: if (reg_ack) begin
          if (!rd_busy) begin
            pre_q <= reg_rdata[CODE_W-1:0];
            state <= S_CLR;
          end else if (last_try) begin
            done         <= 1'b1;
            rsp_abort    <= 1'b1;
            rsp_timeout  <= 1'b0;
            rsp_code     <= '0;
            rsp_word     <= '0;
            rsp_pre_code <= '0;
            state        <= S_IDLE;
          end else begin
            retry <= retry + 1'b1;
            dly   <= DCW'(DLY - 1);
            state <= S_PRE_DLY;
          end
        end
        S_PRE_DLY: if (dly == '0) state <= S_PRE_RD; else dly <= dly - 1'b1;
        S_CLR:     if (reg_ack) state <= S_ARG;
        S_ARG:     if (reg_ack) state <= S_TRIG;
        S_TRIG: if (reg_ack) begin
          retry <= '0;
          state <= S_POST_RD;
        end
        S_POST_RD: if (reg_ack) begin
          if (!rd_busy) begin
            code_q <= reg_rdata[CODE_W-1:0];
            to_q   <= 1'b0;
            state  <= S_GET;
          end else if (last_try) begin
            code_q <= '0;
            to_q   <= 1'b1;
            state  <= S_GET;
          end else begin
            retry <= retry + 1'b1;
            dly   <= DCW'(DLY - 1);
            state <= S_POST_DLY;
          end
        end
        S_POST_DLY: if (dly == '0) state <= S_POST_RD; else dly <= dly - 1'b1;
        S_GET: if (reg_ack) begin
          done         <= 1'b1;
          rsp_abort    <= 1'b0;
          rsp_timeout  <= to_q;
          rsp_code     <= code_q;
          rsp_word     <= reg_rdata;
          rsp_pre_code <= pre_q;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_retry_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= RCW'(MAX_RETRY));
  assert_gap_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack && !reg_we && reg_addr == A_RSP && reg_rdata == '0 && !last_try) |=> !reg_req);
  assert_abort_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_abort) |-> (rsp_code == '0 && rsp_word == '0 && !rsp_timeout));
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == A_RSP) |-> reg_wdata == '0);
  assert_timeout_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_timeout) |-> rsp_code == '0);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_ready_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !reg_req);
  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));
endmodule

// File: tb/sim_mbox_seq.sv
module sim_mbox_seq;
  localparam int CPU = 2, PUS = 2, MR = 3, D = CPU * PUS;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_id = '0;
  logic [31:0] req_arg = '0;
  logic        req_ready, reg_req, reg_we, done, rsp_timeout, rsp_abort;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, rsp_word, rsp_arg;
  logic [31:0] reg_rdata = '0;
  logic        reg_ack = 1'b0;
  logic [7:0]  rsp_code, rsp_pre_code, rsp_id;

  always #4 clk = ~clk;

  mbox_seq #(.CYC_PER_US(CPU), .POLL_US(PUS), .MAX_RETRY(MR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_arg(req_arg), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .done(done), .rsp_code(rsp_code), .rsp_pre_code(rsp_pre_code), .rsp_word(rsp_word),
    .rsp_timeout(rsp_timeout), .rsp_abort(rsp_abort), .rsp_id(rsp_id), .rsp_arg(rsp_arg));

  int checks = 0, errors = 0, gchecks = 0, gerrors = 0;
  int pre_z = 0, post_z = 0, lat = 0;
  logic [31:0] pre_val = 32'h1, fin_val = 32'h1, reply = '0;

  int pre_reads, post_reads, wr_n, lat_cnt;
  logic post_phase;
  logic [31:0] r_arg;
  logic [1:0]  wa [0:7];
  logic [31:0] wd [0:7];

  always @(posedge clk) begin
    reg_ack <= 1'b0;
    if (req_valid && req_ready) begin
      pre_reads <= 0; post_reads <= 0; wr_n <= 0; lat_cnt <= 0; post_phase <= 1'b0;
    end else if (reg_req && !reg_ack) begin
      if (lat_cnt < lat) lat_cnt <= lat_cnt + 1;
      else begin
        lat_cnt <= 0;
        reg_ack <= 1'b1;
        if (reg_we) begin
          if (wr_n < 8) begin wa[wr_n] <= reg_addr; wd[wr_n] <= reg_wdata; end
          wr_n <= wr_n + 1;
          if (reg_addr == 2'd1) r_arg <= reg_wdata;
          if (reg_addr == 2'd0) post_phase <= 1'b1;
        end else if (reg_addr == 2'd2) begin
          if (!post_phase) begin
            reg_rdata <= (pre_reads < pre_z) ? 32'h0 : pre_val;
            pre_reads <= pre_reads + 1;
          end else begin
            if (post_reads < post_z) reg_rdata <= 32'h0;
            else begin reg_rdata <= fin_val; r_arg <= reply; end
            post_reads <= post_reads + 1;
          end
        end else reg_rdata <= r_arg;
      end
    end
  end

  int  gap;
  logic prev_zero;
  always @(posedge clk) begin
    if (req_valid && req_ready) begin prev_zero <= 1'b0; gap <= 0; end
    else if (!reg_req) gap <= gap + 1;
    else if (reg_ack && !reg_we && reg_addr == 2'd2) begin
      if (prev_zero) begin
        gchecks <= gchecks + 1;
        if (gap != D) begin
          gerrors <= gerrors + 1;
          $display("FAIL R2 poll gap actual=%0d expected=%0d", gap, D);
        end
      end
      prev_zero <= (reg_rdata == 32'h0);
      gap <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks + gchecks, errors + gerrors);
    $finish;
  endtask

  task automatic run(input int p, input int q, input logic [7:0] id, input logic [31:0] arg,
                     input logic [7:0] code, input logic [31:0] pv);
    bit ab, tmo;
    int n;
    pre_z = p; post_z = q; pre_val = pv;
    fin_val = 32'h0000_3400 | 32'(code);
    reply = arg * 3 + 32'(id);
    lat = (p + q) % 3;
    @(negedge clk);
    req_id = id; req_arg = arg; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      chk(!req_ready, "R8 ready while busy", 32'(req_ready), 0);
      @(negedge clk); n++;
    end
    ab  = (p > MR);
    tmo = !ab && (q > MR);
    chk(req_ready, "R8 ready with done", 32'(req_ready), 1);
    chk(rsp_abort == ab, "R3 abort flag", 32'(rsp_abort), 32'(ab));
    chk(rsp_timeout == tmo, "R6 timeout flag", 32'(rsp_timeout), 32'(tmo));
    chk(pre_reads == (ab ? MR + 1 : p + 1), "R2 pre reads", pre_reads, ab ? MR + 1 : p + 1);
    if (ab) begin
      chk(wr_n == 0, "R3 no writes", wr_n, 0);
      chk(rsp_code == 0 && rsp_word == 0, "R3 code/word", rsp_word, 0);
      chk(rsp_pre_code == 0, "R7 pre code after abort", rsp_pre_code, 0);
    end else begin
      chk(wr_n == 3, "R4 write count", wr_n, 3);
      chk(wa[0] == 2 && wd[0] == 0, "R4 first write", {wa[0], wd[0][29:0]}, 32'h8000_0000);
      chk(wa[1] == 1 && wd[1] == arg, "R4 second write", wd[1], arg);
      chk(wa[2] == 0 && wd[2] == 32'(id), "R4 trigger write", wd[2], 32'(id));
      chk(rsp_pre_code == pv[7:0], "R7 pre code", rsp_pre_code, pv[7:0]);
      chk(post_reads == (tmo ? MR + 1 : q + 1), "R2 post reads", post_reads, tmo ? MR + 1 : q + 1);
      if (tmo) begin
        chk(rsp_code == 0, "R6 code", rsp_code, 0);
        chk(rsp_word == arg, "R6 word", rsp_word, arg);
        chk(rsp_id == id && rsp_arg == arg, "R6 id/arg", rsp_arg, arg);
      end else begin
        chk(rsp_code == code, "R5 code", rsp_code, code);
        chk(rsp_word == reply, "R5 word", rsp_word, reply);
      end
    end
    @(negedge clk);
    chk(!done, "R8 done pulse width", 32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !reg_req && !rsp_timeout && !rsp_abort, "R1 reset state",
        {done, reg_req, rsp_timeout, rsp_abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !reg_req, "R1 after release", 32'(req_ready), 1);
    for (int p = 0; p <= MR + 1; p++)
      for (int q = 0; q <= MR + 1; q++) begin
        logic [7:0] c;
        case ((p + q) % 5)
          0: c = 8'h01; 1: c = 8'hFF; 2: c = 8'hFE; 3: c = 8'hFD; default: c = 8'hFC;
        endcase
        run(p, q, 8'(1 + p * 5 + q), 32'h1000_0000 + 32'(p * 977 + q * 31),
            c, (p % 2 == 0) ? 32'h1 : 32'h0000_00FC);
      end
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    report();
  end
endmodule